// File: doc/BRIEF.md
# Jump-and-Link Control Path

This block is the instruction decoder and the next-PC and write-back steering for a single-cycle 32-bit core that runs a MIPS-style instruction set. It owns the program counter register. Each cycle it takes the fetched instruction word, the equality flag from the ALU compare and the value read from the first source register, and it produces the next fetch address and the controls for the register-file write port and the data memory. The ALU, the register file and the memories sit outside the block and are seen only through these ports.

Besides the usual register-register operations, immediate operations, loads, stores, conditional branches and the absolute jump, the block handles two call-related instructions. The first is a call that jumps and saves a return address. It jumps to its target and, in the same cycle, writes PC+4 into register 31. A separate write-back select value routes that link value to the register file. The second is a return that jumps to a register. It uses a second next-PC mux to take the fetch address from the source register value instead of from the instruction's immediate field. It makes no register or memory access. Every pin is a plain control or data signal sampled once per cycle. There is no handshake, because a single-cycle core retires one instruction on every clock.

Top module: `jlc_ctrl_path`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0x00000000 and `rf_we_o`, `mem_we_o` and `mem_re_o` are all 0, whatever the instruction. After a rising clock edge with `rst_n` low, `pc_o` is still 0.
- R2: Register-register format, opcode `instr_i[31:26]`=0x00 with function field `instr_i[5:0]` other than 0x08: `rf_we_o`=1, `rf_waddr_o`=`instr_i[15:11]`, `wb_sel_o`=2'b00 (ALU result), no memory access, and the next PC is PC+4.
- R3: Opcodes 0x08 through 0x0F (immediate ALU forms): `rf_we_o`=1, `rf_waddr_o`=`instr_i[20:16]`, `wb_sel_o`=2'b00. Opcode 0x23 (load): the same, except `wb_sel_o`=2'b01 (memory data) and `mem_re_o`=1. In both cases the next PC is PC+4.
- R4: Opcode 0x2B (store): `mem_we_o`=1, `rf_we_o`=0, `mem_re_o`=0, and the next PC is PC+4.
- R5: Opcode 0x04 branches when `br_eq_i`=1 and opcode 0x05 branches when `br_eq_i`=0. The taken next PC is PC+4 plus the sign-extended `instr_i[15:0]` shifted left by 2. When the branch is not taken, the next PC is PC+4. A branch writes nothing.
- R6: Opcode 0x02 (jump): the next PC is {PC+4[31:28], `instr_i[25:0]`, 2'b00}, and nothing is written.
- R7: Opcode 0x03 (jump-and-link): in one cycle, the next PC is the R6 target, `rf_we_o`=1, `rf_waddr_o`=31 and `wb_sel_o`=2'b10 (PC+4).
- R8: Opcode 0x00 with function 0x08 (jump-register): the next PC is `rs_data_i`, passed through unchanged, and `rf_we_o`, `mem_we_o` and `mem_re_o` are all 0.
- R9: Any other opcode writes nothing, reads no memory, and gives a next PC of PC+4.
- R10: At each rising edge with `rst_n` high, `pc_o` takes the value `pc_next_o` had before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_i | input | 32 | Instruction word fetched at `pc_o` |
| br_eq_i | input | 1 | ALU compare flag: the two source operands are equal |
| rs_data_i | input | 32 | Value read from the first source register |
| pc_o | output | 32 | Current program counter |
| pc_next_o | output | 32 | Fetch address for the next cycle |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write index |
| wb_sel_o | output | 2 | Write-back source: 00 ALU, 01 memory, 10 PC+4 |
| mem_we_o | output | 1 | Data-memory write enable |
| mem_re_o | output | 1 | Data-memory read enable |

## Verification
The bench sweeps all 64 opcodes with both values of the equality flag. For opcode 0x00 it also sweeps all 64 function codes, which separates the jump-register slot from the ordinary register-register operations. Before each trial, a jump-register loads a pseudo-random PC. This way the jump targets show whether the upper PC bits come from PC+4, and the branch targets show whether sign extension works for forward and backward offsets. Directed cases place a jump-and-link at the top of the address space, where PC+4 wraps to zero. They also apply a store while reset is held, to show that the write enables stay low.

// File: rtl/jlc_pkg.sv
package jlc_pkg;

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_JUMP    = 6'h02;
  localparam logic [5:0] OP_CALL    = 6'h03;
  localparam logic [5:0] OP_BR_EQ   = 6'h04;
  localparam logic [5:0] OP_BR_NE   = 6'h05;
  localparam logic [5:0] OP_LOAD    = 6'h23;
  localparam logic [5:0] OP_STORE   = 6'h2B;
  localparam logic [5:0] FN_RETREG  = 6'h08;

  typedef enum logic [1:0] {
    WB_ALU  = 2'b00,
    WB_MEM  = 2'b01,
    WB_LINK = 2'b10
  } wb_sel_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'b00,
    DST_RT   = 2'b01,
    DST_RD   = 2'b10,
    DST_RA   = 2'b11
  } dst_sel_e;

  typedef struct packed {
    logic     rf_we;
    dst_sel_e dst;
    wb_sel_e  wb;
    logic     mem_we;
    logic     mem_re;
    logic     br_eq;
    logic     br_ne;
    logic     jump;
    logic     jreg;
  } ctl_t;

endpackage

// File: rtl/jlc_decode.sv
module jlc_decode
  import jlc_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctl_t       ctl_o
);

  always_comb begin
    ctl_o     = '0;
    ctl_o.dst = DST_NONE;
    ctl_o.wb  = WB_ALU;
    unique casez (opcode_i)
      OP_SPECIAL: begin
        if (funct_i == FN_RETREG) begin
          ctl_o.jreg = 1'b1;
        end else begin
          ctl_o.rf_we = 1'b1;
          ctl_o.dst   = DST_RD;
        end
      end
      OP_JUMP:  ctl_o.jump = 1'b1;
      OP_CALL: begin
        ctl_o.jump  = 1'b1;
        ctl_o.rf_we = 1'b1;
        ctl_o.dst   = DST_RA;
        ctl_o.wb    = WB_LINK;
      end
      OP_BR_EQ: ctl_o.br_eq = 1'b1;
      OP_BR_NE: ctl_o.br_ne = 1'b1;
      6'b001???: begin
        ctl_o.rf_we = 1'b1;
        ctl_o.dst   = DST_RT;
      end
      OP_LOAD: begin
        ctl_o.rf_we  = 1'b1;
        ctl_o.dst    = DST_RT;
        ctl_o.wb     = WB_MEM;
        ctl_o.mem_re = 1'b1;
      end
      OP_STORE: ctl_o.mem_we = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/jlc_next_pc.sv
module jlc_next_pc #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pc_i,
  input  logic [25:0]     jidx_i,
  input  logic [15:0]     imm_i,
  input  logic            br_eq_i,
  input  logic [XLEN-1:0] rs_data_i,
  input  logic            sel_br_eq_i,
  input  logic            sel_br_ne_i,
  input  logic            sel_jump_i,
  input  logic            sel_jreg_i,
  output logic [XLEN-1:0] pc_plus4_o,
  output logic [XLEN-1:0] pc_next_o
);

  localparam int SEXT_W = XLEN - 18;

  logic [XLEN-1:0] jmp_tgt;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] seq_or_br;
  logic [XLEN-1:0] imm_or_seq;
  logic            br_taken;

  assign pc_plus4_o = pc_i + XLEN'(4);
  assign jmp_tgt    = {pc_plus4_o[XLEN-1:28], jidx_i, 2'b00};
  assign br_tgt     = pc_plus4_o + {{SEXT_W{imm_i[15]}}, imm_i, 2'b00};
  assign br_taken   = (sel_br_eq_i & br_eq_i) | (sel_br_ne_i & ~br_eq_i);

  // first mux: sequential or branch; second: immediate jump; third: register jump
  assign seq_or_br  = br_taken   ? br_tgt    : pc_plus4_o;
  assign imm_or_seq = sel_jump_i ? jmp_tgt   : seq_or_br;
  assign pc_next_o  = sel_jreg_i ? rs_data_i : imm_or_seq;

  // R5: at most one kind of control transfer is selected per instruction
  AST_ONE_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_jreg_i, sel_jump_i, sel_br_eq_i | sel_br_ne_i})); // R5

endmodule

// File: rtl/jlc_wb_steer.sv
module jlc_wb_steer
  import jlc_pkg::*;
#(
  parameter int REG_AW   = 5,
  parameter int LINK_IDX = 31
) (
  input  logic              rst_n,
  input  logic              rf_we_i,
  input  dst_sel_e          dst_i,
  input  wb_sel_e           wb_i,
  input  logic              mem_we_i,
  input  logic              mem_re_i,
  input  logic [REG_AW-1:0] rt_i,
  input  logic [REG_AW-1:0] rd_i,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [1:0]        wb_sel_o,
  output logic              mem_we_o,
  output logic              mem_re_o
);

  localparam logic [REG_AW-1:0] LINK_REG = REG_AW'(LINK_IDX);

  always_comb begin
    unique case (dst_i)
      DST_RT:  rf_waddr_o = rt_i;
      DST_RD:  rf_waddr_o = rd_i;
      DST_RA:  rf_waddr_o = LINK_REG;
      default: rf_waddr_o = '0;
    endcase
  end

  assign wb_sel_o = wb_i;
  assign rf_we_o  = rst_n & rf_we_i;
  assign mem_we_o = rst_n & mem_we_i;
  assign mem_re_o = rst_n & mem_re_i;

endmodule

// File: rtl/jlc_ctrl_path.sv
module jlc_ctrl_path
  import jlc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int REG_AW   = 5,
  parameter int LINK_IDX = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       instr_i,
  input  logic              br_eq_i,
  input  logic [XLEN-1:0]   rs_data_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   pc_next_o,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [1:0]        wb_sel_o,
  output logic              mem_we_o,
  output logic              mem_re_o
);

  localparam logic [XLEN-1:0] PC_RESET = '0;

  ctl_t            ctl;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_plus4;

  jlc_decode u_decode (
    .opcode_i (instr_i[31:26]),
    .funct_i  (instr_i[5:0]),
    .ctl_o    (ctl)
  );

  jlc_next_pc #(.XLEN(XLEN)) u_next_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc_i        (pc_q),
    .jidx_i      (instr_i[25:0]),
    .imm_i       (instr_i[15:0]),
    .br_eq_i     (br_eq_i),
    .rs_data_i   (rs_data_i),
    .sel_br_eq_i (ctl.br_eq),
    .sel_br_ne_i (ctl.br_ne),
    .sel_jump_i  (ctl.jump),
    .sel_jreg_i  (ctl.jreg),
    .pc_plus4_o  (pc_plus4),
    .pc_next_o   (pc_next_o)
  );

  jlc_wb_steer #(.REG_AW(REG_AW), .LINK_IDX(LINK_IDX)) u_wb_steer (
    .rst_n      (rst_n),
    .rf_we_i    (ctl.rf_we),
    .dst_i      (ctl.dst),
    .wb_i       (ctl.wb),
    .mem_we_i   (ctl.mem_we),
    .mem_re_i   (ctl.mem_re),
    .rt_i       (instr_i[20:16]),
    .rd_i       (instr_i[15:11]),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .wb_sel_o   (wb_sel_o),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= PC_RESET;
    else        pc_q <= pc_next_o;
  end

  assign pc_o = pc_q;

  AST_CALL_LINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_i[31:26] == OP_CALL) |-> (rf_we_o && rf_waddr_o == REG_AW'(LINK_IDX)
      && wb_sel_o == 2'b10 && pc_next_o == {pc_plus4[XLEN-1:28], instr_i[25:0], 2'b00})); // R7

  AST_RETREG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_i[31:26] == OP_SPECIAL && instr_i[5:0] == FN_RETREG)
      |-> (!rf_we_o && !mem_we_o && !mem_re_o && pc_next_o == rs_data_i)); // R8

  AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_i[31:26] == OP_STORE) |-> (mem_we_o && !rf_we_o && !mem_re_o)); // R4

  AST_PC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pc_o == $past(pc_next_o))); // R10

endmodule

// File: tb/sim_jlc_ctrl_path.sv
`timescale 1ns/1ps
module sim_jlc_ctrl_path;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = 32'h0;
  logic        eq = 1'b0;
  logic [31:0] rs = 32'h0;
  logic [31:0] pc_o, pc_next_o;
  logic        rf_we_o, mem_we_o, mem_re_o;
  logic [4:0]  rf_waddr_o;
  logic [1:0]  wb_sel_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;
  bit done = 1'b0;

  always #2 clk = ~clk;

  jlc_ctrl_path u0 (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .br_eq_i(eq), .rs_data_i(rs),
    .pc_o(pc_o), .pc_next_o(pc_next_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
    .wb_sel_o(wb_sel_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o)
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Applies one instruction for one cycle, checks the controls, then the PC after the edge.
  task automatic apply(input logic [31:0] ins, input logic e, input logic [31:0] rv);
    logic [31:0] pc, pc4, nxt, btgt;
    logic [5:0]  op, fn;
    logic        we, mw, mr;
    logic [4:0]  wa;
    logic [1:0]  wb;
    string       tag;
    instr = ins; eq = e; rs = rv;
    #1;
    pc = pc_o; pc4 = pc + 32'd4;
    op = ins[31:26]; fn = ins[5:0];
    btgt = pc4 + {{14{ins[15]}}, ins[15:0], 2'b00};
    we = 0; mw = 0; mr = 0; wa = 0; wb = 2'b00; nxt = pc4; tag = "R9";
    if (op == 6'h00 && fn == 6'h08) begin tag = "R8"; nxt = rv; end
    else if (op == 6'h00) begin tag = "R2"; we = 1; wa = ins[15:11]; end
    else if (op >= 6'h08 && op <= 6'h0F) begin tag = "R3"; we = 1; wa = ins[20:16]; end
    else if (op == 6'h23) begin tag = "R3"; we = 1; wa = ins[20:16]; wb = 2'b01; mr = 1; end
    else if (op == 6'h2B) begin tag = "R4"; mw = 1; end
    else if (op == 6'h04) begin tag = "R5"; if (e) nxt = btgt; end
    else if (op == 6'h05) begin tag = "R5"; if (!e) nxt = btgt; end
    else if (op == 6'h02) begin tag = "R6"; nxt = {pc4[31:28], ins[25:0], 2'b00}; end
    else if (op == 6'h03) begin tag = "R7"; nxt = {pc4[31:28], ins[25:0], 2'b00}; we = 1; wa = 5'd31; wb = 2'b10; end
    chk(tag, "controls {we,waddr,wb,mem_we,mem_re}",
        {22'h0, rf_we_o, rf_waddr_o, wb_sel_o, mem_we_o, mem_re_o},
        {22'h0, we, wa, wb, mw, mr});
    chk(tag, "next pc", pc_next_o, nxt);
    @(posedge clk); #1;
    chk("R10", "pc after edge", pc_o, nxt);
  endtask

  task automatic set_pc(input logic [31:0] v);
    apply({6'h00, 5'd31, 15'h0, 6'h08}, 1'b0, v); // R8 jump-register
  endtask

  initial begin
    // R1: reset holds the PC at zero and blocks writes even for a store
    instr = {6'h2B, 26'h0ABCDEF}; rs = 32'h5555_0000;
    #1;
    chk("R1", "pc in reset", pc_o, 32'h0);
    chk("R1", "enables in reset", {29'h0, rf_we_o, mem_we_o, mem_re_o}, 32'h0);
    instr = {6'h03, 26'h1234567};
    @(posedge clk); @(posedge clk); #1;
    chk("R1", "pc after edges in reset", pc_o, 32'h0);
    chk("R1", "link write blocked in reset", {31'h0, rf_we_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    // directed: call at the top of the address space, PC+4 wraps to zero (R7)
    set_pc(32'hFFFF_FFFC);
    apply({6'h03, 26'h3FFFFFF}, 1'b0, 32'h0);
    // backward and forward branches (R5)
    set_pc(32'h0000_1000);
    apply({6'h04, 5'd1, 5'd2, 16'hFFFE}, 1'b1, 32'h0);
    apply({6'h05, 5'd1, 5'd2, 16'h7FFF}, 1'b0, 32'h0);
    apply({6'h05, 5'd1, 5'd2, 16'h0040}, 1'b1, 32'h0);
    // R8: odd register value passes through unchanged
    apply({6'h00, 5'd7, 15'h0, 6'h08}, 1'b1, 32'h8765_4323);

    // sweep of all opcodes with both flag values
    for (int op = 0; op < 64; op++) begin
      for (int e = 0; e < 2; e++) begin
        set_pc({rnd()} & 32'hFFFF_FFFC);
        apply({op[5:0], rnd()[25:0]}, e[0], rnd());
      end
    end
    // sweep of all function codes under opcode 0
    for (int fn = 0; fn < 64; fn++) begin
      for (int e = 0; e < 2; e++) begin
        set_pc({rnd()} & 32'hFFFF_FFFC);
        apply({6'h00, rnd()[25:6], fn[5:0]}, e[0], rnd());
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule